// File: doc/BRIEF.md
# Coalescing Acknowledge Tracker for a Single Interrupt Line

This block watches one edge-triggered interrupt line whose acknowledgements must be counted. When a message for that line is handed to a set of destinations, the delivery logic reports which destinations took it. The tracker keeps that set as a bitmap and keeps the size of the set as a pending count. Each destination later returns an end-of-interrupt (EOI) carrying its index. An EOI clears that destination's bit and lowers the count.

While any acknowledgement is still outstanding, a fresh assertion of the line is refused and flagged as coalesced. When the count is zero, a fresh assertion is granted, which tells the surrounding logic that it may start a delivery.

A rebuild port overwrites the bitmap in one cycle from a per-destination pending vector, and the count is recomputed from that vector. Surrounding logic uses it to recover if it finds the tracker out of step with the destinations. The delivery itself is handled elsewhere.

Top module: `coal_tracker`

## Requirements
- R1: A synchronous reset clears the bitmap and the pending count, and drives `coalesced` and `grant` low on the cycle after the reset edge, whatever the other inputs are.
- R2: `line_assert` sampled while the pending count is non-zero gives `coalesced`=1 and `grant`=0 in the next cycle.
- R3: `line_assert` sampled while the pending count is zero gives `grant`=1 and `coalesced`=0 in the next cycle. With `line_assert` low, both flags are 0 in the next cycle.
- R4: `dlv_valid`=1 with `dlv_ok`=1, sampled while the count is zero, loads `dlv_accept_map` into the bitmap (bit i stands for destination i). The count becomes the number of set bits in that map.
- R5: `dlv_valid`=1 with `dlv_ok`=0, sampled while the count is zero, leaves the bitmap empty and the count at 0.
- R6: `dlv_valid` sampled while the count is non-zero is ignored. The bitmap and the count are unchanged.
- R7: `eoi_valid` with `eoi_dest`=i, where bit i is set, clears bit i and lowers the count by one in the next cycle.
- R8: An EOI naming a destination whose bit is already clear has no effect on the bitmap or the count.
- R9: The count never wraps below zero. An EOI at count 0 leaves it at 0, and the count always equals the number of set bits in the bitmap.
- R10: `rebuild_valid` loads `rebuild_pending` into the bitmap and sets the count to its number of set bits in one cycle. It takes priority over a delivery and over an EOI in the same cycle. A delivery, in turn, takes priority over an EOI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_assert | input | 1 | New assertion of the tracked line |
| dlv_valid | input | 1 | Delivery result is presented this cycle |
| dlv_ok | input | 1 | Delivery succeeded (0 means failed) |
| dlv_accept_map | input | NUM_DEST | Destinations that accepted the delivery |
| eoi_valid | input | 1 | EOI received this cycle |
| eoi_dest | input | IDX_W | Index of the destination sending the EOI |
| rebuild_valid | input | 1 | Overwrite the bitmap from `rebuild_pending` |
| rebuild_pending | input | NUM_DEST | Per-destination pending status used for a rebuild |
| coalesced | output | 1 | Registered: the last assertion was refused |
| grant | output | 1 | Registered: the last assertion was accepted, so delivery may start |
| pend_count | output | CNT_W | Number of outstanding acknowledgements |

## Verification
The properties assume that `eoi_dest` names a real destination and that reset is held for at least one edge before traffic starts. The stimulus only produces EOI indices within `NUM_DEST` and releases reset after three cycles. The underflow property relies on the rebuild and delivery paths being the only loaders of the bitmap. For that reason the bench loads the bitmap only through those ports. It never forces an EOI-driven decrement while the tracker is idle, except to show that such an EOI is ignored.

// File: rtl/coal_pkg.sv
package coal_pkg;
  // Update applied to the destination bitmap and count on the next edge.
  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_REBUILD = 2'd1,
    OP_DELIVER = 2'd2,
    OP_ACK     = 2'd3
  } coal_op_e;
endpackage

// File: rtl/coal_popcount.sv
module coal_popcount #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/coal_op_sel.sv
module coal_op_sel
  import coal_pkg::*;
(
  input  logic     rebuild_valid,
  input  logic     dlv_valid,
  input  logic     eoi_valid,
  input  logic     idle,
  input  logic     eoi_hit,
  output coal_op_e op
);
  // Priority: rebuild, then delivery (only while idle), then a hitting EOI.
  always_comb begin
    if (rebuild_valid)               op = OP_REBUILD;
    else if (dlv_valid && idle)      op = OP_DELIVER;
    else if (eoi_valid && eoi_hit)   op = OP_ACK;
    else                             op = OP_HOLD;
  end
endmodule

// File: rtl/coal_dest_map.sv
module coal_dest_map
  import coal_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  coal_op_e      op,
  input  logic [N-1:0]  load_vec,
  input  logic [IW-1:0] eoi_dest,
  output logic [N-1:0]  map_q,
  output logic          eoi_hit
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        map_q[g] <= 1'b0;
      end else begin
        case (op)
          OP_REBUILD, OP_DELIVER: map_q[g] <= load_vec[g];
          OP_ACK: if (eoi_dest == IW'(g)) map_q[g] <= 1'b0;
          default: map_q[g] <= map_q[g];
        endcase
      end
    end
  end

  always_comb begin
    eoi_hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (eoi_dest == IW'(i)) eoi_hit = map_q[i];
    end
  end

  // The bit named by an acknowledged EOI must be clear afterwards.
  AST_ACK_CLEARS_BIT: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ACK) |=> !$past(eoi_hit) || (map_q != $past(map_q))); // R7
endmodule

// File: rtl/coal_count_reg.sv
module coal_count_reg
  import coal_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  coal_op_e      op,
  input  logic [CW-1:0] load_cnt,
  output logic [CW-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else begin
      case (op)
        OP_REBUILD, OP_DELIVER: count_q <= load_cnt;
        OP_ACK:                 count_q <= count_q - 1'b1;
        default:                count_q <= count_q;
      endcase
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ACK) |-> (count_q != '0)); // R9
  AST_ACK_DECREMENTS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ACK) |=> (count_q == CW'($past(count_q) - 1'b1))); // R7
endmodule

// File: rtl/coal_tracker.sv
module coal_tracker
  import coal_pkg::*;
#(
  parameter int NUM_DEST = 8,
  localparam int IDX_W = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
  localparam int CNT_W = $clog2(NUM_DEST + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                line_assert,
  input  logic                dlv_valid,
  input  logic                dlv_ok,
  input  logic [NUM_DEST-1:0] dlv_accept_map,
  input  logic                eoi_valid,
  input  logic [IDX_W-1:0]    eoi_dest,
  input  logic                rebuild_valid,
  input  logic [NUM_DEST-1:0] rebuild_pending,
  output logic                coalesced,
  output logic                grant,
  output logic [CNT_W-1:0]    pend_count
);
  coal_op_e            op;
  logic                idle;
  logic                eoi_hit;
  logic [NUM_DEST-1:0] map_q;
  logic [NUM_DEST-1:0] load_vec;
  logic [CNT_W-1:0]    load_cnt;

  assign idle     = (pend_count == '0);
  assign load_vec = rebuild_valid ? rebuild_pending
                  : (dlv_ok ? dlv_accept_map : '0);

  coal_op_sel u_sel (
    .rebuild_valid (rebuild_valid),
    .dlv_valid     (dlv_valid),
    .eoi_valid     (eoi_valid),
    .idle          (idle),
    .eoi_hit       (eoi_hit),
    .op            (op)
  );

  coal_popcount #(.N(NUM_DEST), .CW(CNT_W)) u_pop (
    .vec (load_vec),
    .cnt (load_cnt)
  );

  coal_dest_map #(.N(NUM_DEST), .IW(IDX_W)) u_map (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_vec (load_vec),
    .eoi_dest (eoi_dest),
    .map_q    (map_q),
    .eoi_hit  (eoi_hit)
  );

  coal_count_reg #(.CW(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_cnt (load_cnt),
    .count_q  (pend_count)
  );

  // Registered verdict on an assertion of the line.
  always_ff @(posedge clk) begin
    if (rst) begin
      coalesced <= 1'b0;
      grant     <= 1'b0;
    end else begin
      coalesced <= line_assert && !idle;
      grant     <= line_assert && idle;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pend_count == '0) && !coalesced && !grant); // R1
  AST_COALESCE_PENDING: assert property (@(posedge clk) disable iff (rst)
    (line_assert && pend_count != '0) |=> coalesced && !grant); // R2
  AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (line_assert && pend_count == '0) |=> grant && !coalesced); // R3
  AST_DELIVER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!rebuild_valid && dlv_valid && dlv_ok && pend_count == '0)
      |=> (map_q == $past(dlv_accept_map))); // R4
  AST_FAILED_DELIVERY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!rebuild_valid && dlv_valid && !dlv_ok && pend_count == '0)
      |=> (map_q == '0) && (pend_count == '0)); // R5
  AST_BUSY_DELIVER_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!rebuild_valid && dlv_valid && pend_count != '0 && !eoi_valid)
      |=> $stable(map_q) && $stable(pend_count)); // R6
  AST_MISS_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (!rebuild_valid && !(dlv_valid && pend_count == '0) && eoi_valid && !eoi_hit)
      |=> $stable(map_q) && $stable(pend_count)); // R8
  AST_COUNT_TRACKS_MAP: assert property (@(posedge clk) disable iff (rst)
    32'(pend_count) == $countones(map_q)); // R9
  AST_REBUILD_LOAD: assert property (@(posedge clk) disable iff (rst)
    rebuild_valid |=> (map_q == $past(rebuild_pending))); // R10
endmodule

// File: tb/coal_tracker_bench.sv
`timescale 1ns/1ps
module coal_tracker_bench;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int CW = 4;
  localparam int NV = 21;

  // Row layout: [39] assert, [38] dlv_valid, [37] dlv_ok, [36:29] accept map,
  // [28] eoi_valid, [27:25] eoi_dest, [24] rebuild, [23:16] rebuild map,
  // [15] exp coalesced, [14] exp grant, [13:10] exp count, [9:0] requirement number.
  localparam logic [39:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,8'h00,1'b0,3'd0,1'b0,8'h00,1'b0,1'b1,4'd0,10'd3},  // R3 idle grant
    {1'b0,1'b1,1'b1,8'h0B,1'b0,3'd0,1'b0,8'h00,1'b0,1'b0,4'd3,10'd4},  // R4 load 3
    {1'b1,1'b0,1'b0,8'h00,1'b0,3'd0,1'b0,8'h00,1'b1,1'b0,4'd3,10'd2},  // R2 coalesce
    {1'b0,1'b0,1'b0,8'h00,1'b1,3'd1,1'b0,8'h00,1'b0,1'b0,4'd2,10'd7},  // R7 ack 1
    {1'b0,1'b0,1'b0,8'h00,1'b1,3'd1,1'b0,8'h00,1'b0,1'b0,4'd2,10'd8},  // R8 repeat
    {1'b0,1'b0,1'b0,8'h00,1'b1,3'd2,1'b0,8'h00,1'b0,1'b0,4'd2,10'd8},  // R8 never set
    {1'b0,1'b1,1'b1,8'hFF,1'b0,3'd0,1'b0,8'h00,1'b0,1'b0,4'd2,10'd6},  // R6 busy
    {1'b0,1'b0,1'b0,8'h00,1'b1,3'd0,1'b0,8'h00,1'b0,1'b0,4'd1,10'd7},  // R7 ack 0
    {1'b1,1'b0,1'b0,8'h00,1'b1,3'd3,1'b0,8'h00,1'b1,1'b0,4'd0,10'd2},  // R2 with last ack
    {1'b0,1'b0,1'b0,8'h00,1'b1,3'd3,1'b0,8'h00,1'b0,1'b0,4'd0,10'd9},  // R9 no wrap
    {1'b1,1'b0,1'b0,8'h00,1'b0,3'd0,1'b0,8'h00,1'b0,1'b1,4'd0,10'd3},  // R3
    {1'b0,1'b1,1'b0,8'hFF,1'b0,3'd0,1'b0,8'h00,1'b0,1'b0,4'd0,10'd5},  // R5 failed
    {1'b1,1'b0,1'b0,8'h00,1'b0,3'd0,1'b0,8'h00,1'b0,1'b1,4'd0,10'd5},  // R5 still idle
    {1'b0,1'b1,1'b1,8'hFF,1'b0,3'd0,1'b0,8'h00,1'b0,1'b0,4'd8,10'd4},  // R4 all
    {1'b0,1'b0,1'b0,8'h00,1'b0,3'd0,1'b1,8'h50,1'b0,1'b0,4'd2,10'd10}, // R10 rebuild
    {1'b0,1'b0,1'b0,8'h00,1'b1,3'd4,1'b0,8'h00,1'b0,1'b0,4'd1,10'd10}, // R10 bit4 kept
    {1'b0,1'b0,1'b0,8'h00,1'b1,3'd5,1'b0,8'h00,1'b0,1'b0,4'd1,10'd10}, // R10 bit5 gone
    {1'b0,1'b1,1'b1,8'hFF,1'b1,3'd6,1'b1,8'h0F,1'b0,1'b0,4'd4,10'd10}, // R10 priority
    {1'b0,1'b0,1'b0,8'h00,1'b0,3'd0,1'b1,8'h00,1'b0,1'b0,4'd0,10'd10}, // R10 empty
    {1'b0,1'b1,1'b1,8'h80,1'b1,3'd7,1'b0,8'h00,1'b0,1'b0,4'd1,10'd4},  // R4 beats EOI
    {1'b0,1'b0,1'b0,8'h00,1'b1,3'd7,1'b0,8'h00,1'b0,1'b0,4'd0,10'd7}   // R7
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          line_assert = 1'b0;
  logic          dlv_valid = 1'b0;
  logic          dlv_ok = 1'b0;
  logic [N-1:0]  dlv_accept_map = '0;
  logic          eoi_valid = 1'b0;
  logic [IW-1:0] eoi_dest = '0;
  logic          rebuild_valid = 1'b0;
  logic [N-1:0]  rebuild_pending = '0;
  logic          coalesced;
  logic          grant;
  logic [CW-1:0] pend_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  coal_tracker #(.NUM_DEST(N)) u_coal_tracker (
    .clk             (clk),
    .rst             (rst),
    .line_assert     (line_assert),
    .dlv_valid       (dlv_valid),
    .dlv_ok          (dlv_ok),
    .dlv_accept_map  (dlv_accept_map),
    .eoi_valid       (eoi_valid),
    .eoi_dest        (eoi_dest),
    .rebuild_valid   (rebuild_valid),
    .rebuild_pending (rebuild_pending),
    .coalesced       (coalesced),
    .grant           (grant),
    .pend_count      (pend_count)
  );

  task automatic check(string req, logic exp_c, logic exp_g, logic [CW-1:0] exp_n);
    checks++;
    if (coalesced !== exp_c || grant !== exp_g || pend_count !== exp_n) begin
      fails++;
      $display("FAIL %s: coalesced=%b grant=%b count=%0d, expected %b %b %0d",
               req, coalesced, grant, pend_count, exp_c, exp_g, exp_n);
    end
  endtask

  task automatic idle_inputs();
    line_assert = 1'b0; dlv_valid = 1'b0; dlv_ok = 1'b0; dlv_accept_map = '0;
    eoi_valid = 1'b0; eoi_dest = '0; rebuild_valid = 1'b0; rebuild_pending = '0;
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", 1'b0, 1'b0, 4'd0);

    for (int v = 0; v < NV; v++) begin
      {line_assert, dlv_valid, dlv_ok, dlv_accept_map, eoi_valid, eoi_dest,
       rebuild_valid, rebuild_pending} = VEC[v][39:16];
      @(negedge clk);
      check($sformatf("R%0d row %0d", VEC[v][9:0], v),
            VEC[v][15], VEC[v][14], VEC[v][13:10]);
    end

    // Reset in the middle of outstanding work, with the line asserted (R1).
    idle_inputs();
    dlv_valid = 1'b1; dlv_ok = 1'b1; dlv_accept_map = 8'h3C;
    @(negedge clk);
    check("R4", 1'b0, 1'b0, 4'd4);
    idle_inputs();
    rst = 1'b1; line_assert = 1'b1; eoi_valid = 1'b1; eoi_dest = 3'd2;
    @(negedge clk);
    check("R1", 1'b0, 1'b0, 4'd0);
    rst = 1'b0;
    idle_inputs();
    line_assert = 1'b1;
    @(negedge clk);
    check("R3 after R1", 1'b0, 1'b1, 4'd0);
    idle_inputs();
    @(negedge clk);
    check("R3 flags drop", 1'b0, 1'b0, 4'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule